// File: doc/BRIEF.md
# Buffered Sample Playback Sequencer

This block streams 12-bit converter codes out of a 256-word sample buffer. A host fills the buffer through a word-wide write port, then programs a pacing divisor, an end address and an interrupt threshold, and sets the run enable. From then on a read pointer steps through the buffer once per pacing period. At every step the low twelve bits of the addressed word appear on the converter data output, together with a one-cycle strobe.

At the end address playback either halts or, in circular mode, returns to word 0 and repeats. An interrupt flag rises when the pointer steps onto the programmed threshold address. It stays raised until the host next writes the control register. Two port-enable bits separately gate host access to the buffer and the playback read path. Clearing the playback gate pauses the sequencer in place.

Top module: `wave_player`

## Requirements
- R1: After reset, sample_strobe, irq, dac_data and buf_rdata are 0, and both registers read back 0.
- R2: While control bit 1 (host write allow) and bit 13 (host port gate) are both 1, a buf_wr stores buf_wdata at buf_addr. A buf_rd with bit 13 set returns that word on buf_rdata one clock later.
- R3: A buf_wr is discarded when control bit 1 or bit 13 is 0. The stored word is unchanged.
- R4: With divisor D in rate-register bits [23:0], sample_strobe pulses high for one cycle once every D+1 cycles while playback runs.
- R5: At each strobe, dac_data carries bits [11:0] of the buffer word at the read pointer, and the pointer then moves up by one. The first strobe after enabling plays word 0. dac_data changes only together with a strobe.
- R6: With control bit 2 clear, the word at the end address (rate-register bits [31:24]) is the last one played. No further strobes occur until the enable is cleared.
- R7: With control bit 2 set, the step after the end address plays word 0 again.
- R8: irq, and readback bit 19, set when a step moves the pointer onto the threshold held in control bits [11:3]. Both stay set until the next control write. A step onto the threshold in the same cycle as a control write leaves them set. A threshold of 256 or more never matches.
- R9: Clearing control bit 0 (run enable) returns the pointer and the pacing counter to 0, and no strobes occur. The next enable starts again at word 0.
- R10: Clearing control bit 14 (playback gate) while running stops strobes and holds the pointer and counter. Setting it again continues from the next word.
- R11: Register 0 reads back control bits [14:0] as written, with bit 12 forced to 0. Bits [18:15] read 0, bit 19 is the threshold flag and bits [31:20] are dac_data. Register 1 reads back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 rate/limit |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Readback of the selected register |
| buf_wr | input | 1 | Host buffer write request |
| buf_rd | input | 1 | Host buffer read request |
| buf_addr | input | 8 | Host buffer word address |
| buf_wdata | input | 32 | Host buffer write data |
| buf_rdata | output | 32 | Host buffer read data, one cycle after buf_rd |
| sample_strobe | output | 1 | One-cycle pulse per played sample |
| dac_data | output | 12 | Current converter code |
| irq | output | 1 | Threshold-crossing interrupt, level |

## Verification
The threshold flag has one set source, a pointer step landing on the threshold, and one clear source, a control-register write. Both can act on the same clock edge. To force the overlap, the bench uses divisor 0, end address 0, circular mode and threshold 0, so the flag is set again on every cycle. It then rewrites the control register. irq must still read 1 at the negedge right after the write edge, and the played code must still be word 0.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;
  localparam int WP_SMP_W = 12;
  localparam int WP_DIV_W = 24;
  localparam int WP_LIM_W = 8;
  localparam int WP_THR_W = 9;
  localparam int WP_REG_W = 32;

  // control register bit positions
  localparam int CB_EN     = 0;
  localparam int CB_WREN   = 1;
  localparam int CB_CIRC   = 2;
  localparam int CB_THR_LO = 3;
  localparam int CB_PORTA  = 13;
  localparam int CB_PORTB  = 14;
  localparam int CB_FLAG   = 19;
  localparam int CB_SMP_LO = 20;
  // rate register field positions
  localparam int RB_DIV_LO = 0;
  localparam int RB_LIM_LO = 24;

  typedef struct packed {
    logic                portb;
    logic                porta;
    logic [WP_THR_W-1:0] thr;
    logic                circ;
    logic                wr_en;
    logic                en;
  } wp_ctrl_t;

  typedef enum logic {
    WP_REG_CTRL = 1'b0,
    WP_REG_RATE = 1'b1
  } wp_reg_e;
endpackage

// File: rtl/wp_regs.sv
`timescale 1ns/1ps
module wp_regs
  import wp_pkg::*;
#(
  parameter int REG_W = WP_REG_W,
  parameter int DIV_W = WP_DIV_W,
  parameter int LIM_W = WP_LIM_W,
  parameter int SMP_W = WP_SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             flag,
  input  logic [SMP_W-1:0] sample,
  output wp_ctrl_t         ctrl,
  output logic [DIV_W-1:0] divisor,
  output logic [LIM_W-1:0] limit,
  output logic             ctrl_wr,
  output logic [REG_W-1:0] reg_rdata
);
  wp_ctrl_t         ctrl_q, ctrl_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [LIM_W-1:0] lim_q, lim_d;
  logic             ctrl_we, rate_we;
  logic [REG_W-1:0] ctrl_rb, rate_rb;

  assign ctrl_we = reg_wr && (reg_addr == WP_REG_CTRL);
  assign rate_we = reg_wr && (reg_addr == WP_REG_RATE);

  always_comb begin
    ctrl_d.en    = reg_wdata[CB_EN];
    ctrl_d.wr_en = reg_wdata[CB_WREN];
    ctrl_d.circ  = reg_wdata[CB_CIRC];
    ctrl_d.thr   = reg_wdata[CB_THR_LO +: WP_THR_W];
    ctrl_d.porta = reg_wdata[CB_PORTA];
    ctrl_d.portb = reg_wdata[CB_PORTB];
    div_d        = reg_wdata[RB_DIV_LO +: DIV_W];
    lim_d        = reg_wdata[RB_LIM_LO +: LIM_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      lim_q <= '0;
    end else if (rate_we) begin
      div_q <= div_d;
      lim_q <= lim_d;
    end
  end

  always_comb begin
    ctrl_rb                          = '0;
    ctrl_rb[CB_EN]                   = ctrl_q.en;
    ctrl_rb[CB_WREN]                 = ctrl_q.wr_en;
    ctrl_rb[CB_CIRC]                 = ctrl_q.circ;
    ctrl_rb[CB_THR_LO +: WP_THR_W]   = ctrl_q.thr;
    ctrl_rb[CB_PORTA]                = ctrl_q.porta;
    ctrl_rb[CB_PORTB]                = ctrl_q.portb;
    ctrl_rb[CB_FLAG]                 = flag;
    ctrl_rb[CB_SMP_LO +: SMP_W]      = sample;
    rate_rb                          = '0;
    rate_rb[RB_DIV_LO +: DIV_W]      = div_q;
    rate_rb[RB_LIM_LO +: LIM_W]      = lim_q;
  end

  assign reg_rdata = (reg_addr == WP_REG_RATE) ? rate_rb : ctrl_rb;
  assign ctrl      = ctrl_q;
  assign divisor   = div_q;
  assign limit     = lim_q;
  assign ctrl_wr   = ctrl_we;
endmodule

// File: rtl/wp_rate_gen.sv
`timescale 1ns/1ps
module wp_rate_gen #(
  parameter int DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  // >= keeps pacing sane if the divisor is lowered below the running count
  assign tick   = run && (cnt_q >= divisor);
  assign cnt_ce = !en || run;

  always_comb begin
    if (!en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wp_play_ptr.sv
`timescale 1ns/1ps
module wp_play_ptr #(
  parameter int ADDR_W = 8,
  parameter int THR_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              circ,
  input  logic [ADDR_W-1:0] limit,
  input  logic [THR_W-1:0]  thr,
  input  logic              flag_clr,
  output logic [ADDR_W-1:0] ptr,
  output logic              stopped,
  output logic              flag,
  output logic              strobe
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              stop_q, stop_d;
  logic              flag_q, flag_d;
  logic              strobe_q;
  logic              ptr_ce, at_lim, stop_now, hit;

  assign at_lim   = (ptr_q == limit);
  assign stop_now = tick && at_lim && !circ;
  assign ptr_ce   = !en || tick;

  always_comb begin
    ptr_d  = ptr_q;
    stop_d = stop_q;
    if (!en) begin
      ptr_d  = '0;
      stop_d = 1'b0;
    end else if (tick) begin
      if (at_lim) begin
        ptr_d  = circ ? '0 : ptr_q;
        stop_d = !circ;
      end else begin
        ptr_d  = ptr_q + 1'b1;
      end
    end
  end

  // threshold hit: a step that lands on the threshold (not the halting step)
  assign hit = tick && !stop_now && (THR_W'(ptr_d) == thr);

  always_comb begin
    if (hit) begin
      flag_d = 1'b1;
    end else if (flag_clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      stop_q <= 1'b0;
    end else if (ptr_ce) begin
      ptr_q  <= ptr_d;
      stop_q <= stop_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      flag_q   <= flag_d;
      strobe_q <= tick;
    end
  end

  assign ptr     = ptr_q;
  assign stopped = stop_q;
  assign flag    = flag_q;
  assign strobe  = strobe_q;
endmodule

// File: rtl/wp_buf_ram.sv
`timescale 1ns/1ps
module wp_buf_ram #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter int SMP_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic              rd_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [WORD_W-1:0] wdata_a,
  output logic [WORD_W-1:0] rdata_a,
  input  logic              rd_b,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [SMP_W-1:0]  smp_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdata_q;
  logic [SMP_W-1:0]  smp_q;

  always_ff @(posedge clk) begin
    if (wr_a) begin
      mem[addr_a] <= wdata_a;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_a) begin
      rdata_q <= mem[addr_a];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
    end else if (rd_b) begin
      smp_q <= mem[addr_b][SMP_W-1:0];
    end
  end

  assign rdata_a = rdata_q;
  assign smp_b   = smp_q;
endmodule

// File: rtl/wave_player.sv
`timescale 1ns/1ps
module wave_player
  import wp_pkg::*;
#(
  parameter int WORD_W = WP_REG_W,
  parameter int ADDR_W = WP_LIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              buf_wr,
  input  logic              buf_rd,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [WORD_W-1:0] buf_wdata,
  output logic [WORD_W-1:0] buf_rdata,
  output logic              sample_strobe,
  output logic [WP_SMP_W-1:0] dac_data,
  output logic              irq
);
  wp_ctrl_t             ctrl;
  logic [WP_DIV_W-1:0]  divisor;
  logic [ADDR_W-1:0]    limit;
  logic [ADDR_W-1:0]    ptr;
  logic                 ctrl_wr, tick, run, stopped, flag, strobe;
  logic                 host_wr, host_rd;
  logic [WP_SMP_W-1:0]  sample;
  logic                 ctrl_en, ctrl_portb;

  assign ctrl_en    = ctrl.en;
  assign ctrl_portb = ctrl.portb;
  assign run        = ctrl.en && ctrl.portb && !stopped;
  assign host_wr    = buf_wr && ctrl.wr_en && ctrl.porta;
  assign host_rd    = buf_rd && ctrl.porta;

  wp_regs #(
    .REG_W (WORD_W),
    .DIV_W (WP_DIV_W),
    .LIM_W (ADDR_W),
    .SMP_W (WP_SMP_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flag      (flag),
    .sample    (sample),
    .ctrl      (ctrl),
    .divisor   (divisor),
    .limit     (limit),
    .ctrl_wr   (ctrl_wr),
    .reg_rdata (reg_rdata)
  );

  wp_rate_gen #(
    .DIV_W (WP_DIV_W)
  ) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctrl.en),
    .run     (run),
    .divisor (divisor),
    .tick    (tick)
  );

  wp_play_ptr #(
    .ADDR_W (ADDR_W),
    .THR_W  (WP_THR_W)
  ) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl.en),
    .tick     (tick),
    .circ     (ctrl.circ),
    .limit    (limit),
    .thr      (ctrl.thr),
    .flag_clr (ctrl_wr),
    .ptr      (ptr),
    .stopped  (stopped),
    .flag     (flag),
    .strobe   (strobe)
  );

  wp_buf_ram #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .SMP_W  (WP_SMP_W)
  ) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_a    (host_wr),
    .rd_a    (host_rd),
    .addr_a  (buf_addr),
    .wdata_a (buf_wdata),
    .rdata_a (buf_rdata),
    .rd_b    (tick),
    .addr_b  (ptr),
    .smp_b   (sample)
  );

  assign sample_strobe = strobe;
  assign dac_data      = sample;
  assign irq           = flag;
endmodule

// File: rtl/wave_player_chk.sv
`timescale 1ns/1ps
module wave_player_chk #(
  parameter int SMP_W = 12,
  parameter int DIV_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic             sample_strobe,
  input logic [SMP_W-1:0] dac_data,
  input logic             irq,
  input logic             ctrl_en,
  input logic             ctrl_portb,
  input logic [DIV_W-1:0] divisor
);
  assert_strobe_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && (divisor != '0)) |=> !sample_strobe);

  assert_dac_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_strobe |-> $stable(dac_data));

  assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && (reg_addr == 1'b0))) |=> irq);

  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> sample_strobe);

  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl_en) |-> !sample_strobe);

  assert_paused_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ctrl_portb) |-> !sample_strobe);
endmodule

bind wave_player wave_player_chk #(
  .SMP_W (wp_pkg::WP_SMP_W),
  .DIV_W (wp_pkg::WP_DIV_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .sample_strobe (sample_strobe),
  .dac_data      (dac_data),
  .irq           (irq),
  .ctrl_en       (ctrl_en),
  .ctrl_portb    (ctrl_portb),
  .divisor       (divisor)
);

// File: tb/wave_player_tb.sv
`timescale 1ns/1ps
module wave_player_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_addr, buf_wr, buf_rd;
  logic [31:0] reg_wdata, reg_rdata, buf_wdata, buf_rdata;
  logic [7:0]  buf_addr;
  logic        sample_strobe, irq;
  logic [11:0] dac_data;

  always #2 clk = ~clk;

  wave_player u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_wr(buf_wr),
    .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata), .sample_strobe(sample_strobe),
    .dac_data(dac_data), .irq(irq)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  int unsigned cyc = 0;
  int unsigned prev_cyc = 0;
  int          strobes = 0;
  int          gap_exp = 0;
  bit          prev_ok = 1'b0;
  bit          mon_free = 1'b0;
  bit          finished = 1'b0;
  logic [11:0] exp_q[$];

  function automatic logic [11:0] smp(int i);
    return 12'((i * 291 + 17) & 32'hFFF);
  endfunction

  function automatic logic [31:0] word_of(int i);
    return {12'hC3A, 8'h55, smp(i)};
  endfunction

  function automatic logic [31:0] mk_ctrl(bit en, bit wren, bit circ, int thr, bit pa, bit pb);
    return 32'(en) | (32'(wren) << 1) | (32'(circ) << 2) | ((32'(thr) & 32'h1FF) << 3)
         | (32'(pa) << 13) | (32'(pb) << 14);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(bit a, logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(bit a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic buf_write(int a, logic [31:0] d);
    @(posedge clk); #1;
    buf_wr = 1'b1; buf_addr = 8'(a); buf_wdata = d;
    @(posedge clk); #1;
    buf_wr = 1'b0;
  endtask

  task automatic buf_read(int a, output logic [31:0] d);
    @(posedge clk); #1;
    buf_rd = 1'b1; buf_addr = 8'(a);
    @(posedge clk); #1;
    buf_rd = 1'b0;
    d = buf_rdata;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop one expected code per strobe
  always @(negedge clk) begin
    if (rst_n && sample_strobe) begin
      strobes++;
      if (!mon_free) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R6 unexpected strobe actual dac=%h expected none", dac_data);
        end else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          chk("R5 played sample", 32'(dac_data), 32'(e));
        end
        if (gap_exp != 0 && prev_ok) chk("R4 strobe period", cyc - prev_cyc, 32'(gap_exp));
      end
      prev_ok  = 1'b1;
      prev_cyc = cyc;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R5 watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] c;
    int s0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    buf_wr = 1'b0; buf_rd = 1'b0; buf_addr = '0; buf_wdata = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 strobe", 32'(sample_strobe), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dac", 32'(dac_data), 0);
    chk("R1 buf_rdata", buf_rdata, 0);
    reg_read(1'b0, rd); chk("R1 ctrl readback", rd, 0);
    reg_read(1'b1, rd); chk("R1 rate readback", rd, 0);

    // R11 control readback, reserved bit 12 dropped
    reg_write(1'b0, mk_ctrl(0, 1, 0, 0, 1, 0) | 32'h1000);
    reg_read(1'b0, rd); chk("R11 ctrl readback", rd, mk_ctrl(0, 1, 0, 0, 1, 0));

    // R2 fill and read back
    for (int i = 0; i < 16; i++) buf_write(i, word_of(i));
    buf_read(3, rd); chk("R2 read word 3", rd, word_of(3));
    buf_read(9, rd); chk("R2 read word 9", rd, word_of(9));

    // R3 writes discarded without write allow or without host gate
    reg_write(1'b0, mk_ctrl(0, 0, 0, 0, 1, 0));
    buf_write(3, 32'hFFFF_FFFF);
    buf_read(3, rd); chk("R3 write-allow off", rd, word_of(3));
    reg_write(1'b0, mk_ctrl(0, 1, 0, 0, 0, 0));
    buf_write(4, 32'h0);
    reg_write(1'b0, mk_ctrl(0, 1, 0, 0, 1, 0));
    buf_read(4, rd); chk("R3 host gate off", rd, word_of(4));

    // R4 R5 R6 R8: one-shot 0..5, divisor 3, threshold 4
    reg_write(1'b1, {8'd5, 24'd3});
    reg_read(1'b1, rd); chk("R11 rate readback", rd, {8'd5, 24'd3});
    for (int i = 0; i <= 5; i++) exp_q.push_back(smp(i));
    gap_exp = 4; prev_ok = 1'b0;
    c = mk_ctrl(1, 0, 0, 4, 1, 1);
    reg_write(1'b0, c);
    drain();
    s0 = strobes;
    repeat (40) @(negedge clk);
    chk("R6 halted after end address", 32'(strobes), 32'(s0));
    chk("R8 irq after threshold", 32'(irq), 1);
    reg_read(1'b0, rd);
    chk("R11 flag bit 19", 32'(rd[19]), 1);
    chk("R11 sample field", 32'(rd[31:20]), 32'(smp(5)));
    chk("R11 reserved 18:15", 32'(rd[18:15]), 0);
    reg_write(1'b0, c);
    @(negedge clk);
    chk("R8 cleared by control write", 32'(irq), 0);

    // R9 disable, R7 circular restart from word 0
    reg_write(1'b0, mk_ctrl(0, 0, 0, 0, 1, 1));
    repeat (4) @(negedge clk);
    chk("R9 no strobe while disabled", 32'(strobes), 32'(s0));
    reg_write(1'b1, {8'd2, 24'd3});
    for (int k = 0; k < 7; k++) exp_q.push_back(smp(k % 3));
    prev_ok = 1'b0;
    reg_write(1'b0, mk_ctrl(1, 0, 1, 300, 1, 1));
    drain();
    reg_write(1'b0, mk_ctrl(0, 0, 1, 300, 1, 1));
    chk("R8 threshold above range never fires", 32'(irq), 0);

    // R10 pause and resume
    for (int k = 0; k < 6; k++) exp_q.push_back(smp(k % 3));
    prev_ok = 1'b0;
    reg_write(1'b0, mk_ctrl(1, 0, 1, 300, 1, 1));
    while (exp_q.size() > 4) @(negedge clk);
    gap_exp = 0;
    reg_write(1'b0, mk_ctrl(1, 0, 1, 300, 1, 0));
    s0 = strobes;
    repeat (40) @(negedge clk);
    chk("R10 paused", 32'(strobes), 32'(s0));
    prev_ok = 1'b0; gap_exp = 4;
    reg_write(1'b0, mk_ctrl(1, 0, 1, 300, 1, 1));
    drain();
    reg_write(1'b0, mk_ctrl(0, 0, 1, 300, 1, 1));
    repeat (3) @(negedge clk);

    // R8 collision: step onto threshold every cycle, control write lands on one
    reg_write(1'b1, {8'd0, 24'd0});
    mon_free = 1'b1;
    c = mk_ctrl(1, 0, 1, 0, 1, 1);
    reg_write(1'b0, c);
    repeat (5) @(negedge clk);
    chk("R8 irq with every-cycle hit", 32'(irq), 1);
    reg_write(1'b0, c);
    @(negedge clk);
    chk("R8 set wins over simultaneous clear", 32'(irq), 1);
    chk("R5 single-word loop code", 32'(dac_data), 32'(smp(0)));
    reg_write(1'b0, mk_ctrl(0, 0, 1, 0, 1, 1));
    repeat (3) @(negedge clk);
    mon_free = 1'b0;
    chk("R6 queue empty at end", 32'(exp_q.size()), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule